// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a word-organised memory with two independent ports, called left and right. Each port has its own clock. Either port can read or write any word at any time. Each port has two chip selects: an active-low one and an active-high one. It also has a write strobe, an active-low output enable, and separate write-data and read-data buses. A data-enable output tells an outer pad ring or bus mux when the read data should be driven. The word width is set by `DATA_W` (8 or 9 bits). The depth is 2^`ADDR_W` words. Production builds set `ADDR_W` to 13 for 8K words or 14 for 16K words. The default is reduced to 11 to keep elaboration small.

Each port has its own burst address counter, so a host can send one start address and then stream words without supplying further addresses. Three active-low controls act on the counter, in this priority order: clear, load, step. In a cycle where load is low, the array access uses the address pins. In every other cycle it uses the counter value from before that edge's update. The counter wraps from the top address back to zero.

A per-port latency select sets the read timing. With the select low (flow-through), the data is captured on the access edge. With the select high (pipelined), an extra register stage delays it by one edge. When both ports write the same word on the same edge of a shared clock, the left port's data is kept.

Top module: `dpb_burst_ram`

## Requirements
- R1: A port is selected only while `sel_lo_n_*` is 0 and `sel_hi_*` is 1. An unselected port writes nothing, and the read it leaves behind never raises `dout_en_*`.
- R2: With the port selected and `we_n_*` = 0, `din_*` is stored at the access address on the rising edge. With `we_n_*` = 1, the port performs a read.
- R3: `dout_en_*` is 1 only while `oe_n_*` is 0 and the output stage holds valid read data. It follows `oe_n_*` without waiting for a clock.
- R4: With `lat2_*` = 0 (flow-through), data read at edge k appears on `dout_*`, with `dout_en_*` = 1, right after edge k.
- R5: With `lat2_*` = 1 (pipelined), data read at edge k appears right after edge k+1. Right after edge k, `dout_en_*` is 0 if the preceding cycle made no read.
- R6: `ld_n_*` = 0 (with `clr_n_*` = 1) loads the counter with `addr_*` at the edge.
- R7: `inc_n_*` = 0 adds one to the counter at each edge. It is ignored while `ld_n_*` or `clr_n_*` is 0. With all three controls at 1, the counter holds its value.
- R8: `clr_n_*` = 0 sets the counter to zero. This overrides both load and step.
- R9: The access address is `addr_*` when `ld_n_*` = 0. Otherwise it is the counter value from before the edge's update.
- R10: Stepping from 2^ADDR_W−1 gives 0.
- R11: Data written through one port can be read through the other port. Writes to different words on the same edge both take effect.
- R12: When both ports write the same word on the same edge of a common clock, the left port's data is stored.
- R13: Synchronous active-low `rst_n` clears both counters to zero and holds both `dout_en_*` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by both port clocks |
| clk_l | input | 1 | Left port clock |
| addr_l | input | ADDR_W | Left address, used for access and counter load |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data |
| dout_en_l | output | 1 | Left read data valid and enabled |
| sel_lo_n_l | input | 1 | Left chip select, active low |
| sel_hi_l | input | 1 | Left chip select, active high |
| we_n_l | input | 1 | Left write strobe: 0 writes, 1 reads |
| oe_n_l | input | 1 | Left output enable, active low |
| ld_n_l | input | 1 | Left counter load / use address pins, active low |
| inc_n_l | input | 1 | Left counter step, active low |
| clr_n_l | input | 1 | Left counter clear, active low |
| lat2_l | input | 1 | Left read latency: 0 flow-through, 1 pipelined |
| clk_r | input | 1 | Right port clock |
| addr_r | input | ADDR_W | Right address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data |
| dout_en_r | output | 1 | Right read data valid and enabled |
| sel_lo_n_r | input | 1 | Right chip select, active low |
| sel_hi_r | input | 1 | Right chip select, active high |
| we_n_r | input | 1 | Right write strobe: 0 writes, 1 reads |
| oe_n_r | input | 1 | Right output enable, active low |
| ld_n_r | input | 1 | Right counter load, active low |
| inc_n_r | input | 1 | Right counter step, active low |
| clr_n_r | input | 1 | Right counter clear, active low |
| lat2_r | input | 1 | Right read latency select |

## Verification
The hardest case to reach from the ports is the counter's internal state, since the counter has no output of its own. The bench exposes it by making counter-addressed writes on one port and then reading each word back through the other port with explicit addresses. The write sequences are chosen so that a wrong priority, a step taken during a load, or a missed wrap leaves a different value in a known word. The same-word collision needs both ports to write on one edge of a shared clock. The bench drives both ports with identical timing so that their writes meet on the same edge.

// File: rtl/dpb_pkg.sv
// Package: shared defaults and the burst-counter decision for the dual-port
// burst RAM. Assumes active-low counter controls.
package dpb_pkg;

    parameter int unsigned DEF_ADDR_W = 11;
    parameter int unsigned DEF_DATA_W = 9;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_LOAD  = 2'd2,
        CNT_STEP  = 2'd3
    } cnt_op_e;

    // Pick the counter action; clear beats load, load beats step.
    function automatic cnt_op_e cnt_decide(input logic clr_n, input logic ld_n,
                                           input logic inc_n);
        if (!clr_n)      return CNT_CLEAR;
        else if (!ld_n)  return CNT_LOAD;
        else if (!inc_n) return CNT_STEP;
        else             return CNT_HOLD;
    endfunction

endpackage

// File: rtl/dpb_burst_counter.sv
// Module: per-port burst address counter with prioritised clear, load and
// step. It wraps at 2^ADDR_W and runs whether or not the port is selected.
// Assumes a synchronous active-low reset.
module dpb_burst_counter
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n_i,
    input  logic              ld_n_i,
    input  logic              inc_n_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] cnt_o
);

    cnt_op_e op;

    // Decide the action for this edge.
    always_comb op = cnt_decide(clr_n_i, ld_n_i, inc_n_i);

    // Update the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else begin
            unique case (op)
                CNT_CLEAR: cnt_o <= '0;
                CNT_LOAD:  cnt_o <= load_val_i;
                CNT_STEP:  cnt_o <= cnt_o + 1'b1;
                default:   cnt_o <= cnt_o;
            endcase
        end
    end

endmodule

// File: rtl/dpb_read_stage.sv
// Module: read output registers for one port. Stage one captures the array
// word on a read edge. Stage two copies stage one on every edge. lat2_i
// picks which stage drives the output. Assumes rd_data_i is the combinational
// array word at this cycle's access address.
module dpb_read_stage
    import dpb_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              lat2_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    logic [DATA_W-1:0] s1_data, s2_data;
    logic              s1_vld, s2_vld;

    // First stage: hold data between reads, valid only after a read edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_data <= '0;
            s1_vld  <= 1'b0;
        end else begin
            s1_vld <= capture_i;
            if (capture_i) s1_data <= rd_data_i;
        end
    end

    // Second stage: one extra edge of latency for pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_data <= '0;
            s2_vld  <= 1'b0;
        end else begin
            s2_data <= s1_data;
            s2_vld  <= s1_vld;
        end
    end

    // Select stage by latency mode and gate with output enable.
    always_comb begin
        dout_o    = lat2_i ? s2_data : s1_data;
        dout_en_o = !oe_n_i && (lat2_i ? s2_vld : s1_vld);
    end

endmodule

// File: rtl/dpb_xor_banks.sv
// Module: two-writer storage made of two single-writer banks. A word's value
// is the XOR of both banks. Each port writes its own bank, XOR-ing its data
// with the other bank's word. Assumes the caller has already suppressed one
// writer when both hit the same word on one edge.
module dpb_xor_banks
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk_a,
    input  logic              we_a_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [DATA_W-1:0] wd_a_i,
    output logic [DATA_W-1:0] rd_a_o,
    input  logic              clk_b,
    input  logic              we_b_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    input  logic [DATA_W-1:0] wd_b_i,
    output logic [DATA_W-1:0] rd_b_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] bank_a [DEPTH];
    logic [DATA_W-1:0] bank_b [DEPTH];

    // Start both banks equal so every word reads as zero.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            bank_a[i] = '0;
            bank_b[i] = '0;
        end
    end

    // Port A writes its bank.
    always_ff @(posedge clk_a) begin
        if (we_a_i) bank_a[addr_a_i] <= wd_a_i ^ bank_b[addr_a_i];
    end

    // Port B writes its bank.
    always_ff @(posedge clk_b) begin
        if (we_b_i) bank_b[addr_b_i] <= wd_b_i ^ bank_a[addr_b_i];
    end

    // Combine both banks for each read address.
    always_comb begin
        rd_a_o = bank_a[addr_a_i] ^ bank_b[addr_a_i];
        rd_b_o = bank_b[addr_b_i] ^ bank_a[addr_b_i];
    end

endmodule

// File: rtl/dpb_port.sv
// Module: control for one port. It decodes the chip selects and read/write,
// picks the access address (pins on load, counter otherwise), and holds the
// burst counter and read output stages. Assumes rd_data_i comes from
// storage at acc_addr_o.
module dpb_port
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_lo_n_i,
    input  logic              sel_hi_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              ld_n_i,
    input  logic              inc_n_i,
    input  logic              clr_n_i,
    input  logic              lat2_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] cnt_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    logic sel, rd;

    // Decode selection and direction, then pick the access address.
    always_comb begin
        sel        = !sel_lo_n_i && sel_hi_i;
        wr_o       = sel && !we_n_i;
        rd         = sel && we_n_i;
        acc_addr_o = !ld_n_i ? addr_i : cnt_o;
    end

    dpb_burst_counter #(.ADDR_W(ADDR_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n_i    (clr_n_i),
        .ld_n_i     (ld_n_i),
        .inc_n_i    (inc_n_i),
        .load_val_i (addr_i),
        .cnt_o      (cnt_o)
    );

    dpb_read_stage #(.DATA_W(DATA_W)) rdst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (rd),
        .rd_data_i (rd_data_i),
        .lat2_i    (lat2_i),
        .oe_n_i    (oe_n_i),
        .dout_o    (dout_o),
        .dout_en_o (dout_en_o)
    );

endmodule

// File: rtl/dpb_burst_ram.sv
// Module: top of the dual-port burst RAM. It holds two port controllers and
// the shared storage. When both ports write the same word, the right write
// is dropped. This arbitration assumes both port clocks are the same clock.
module dpb_burst_ram
    import dpb_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              rst_n,
    input  logic              clk_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] din_l,
    output logic [DATA_W-1:0] dout_l,
    output logic              dout_en_l,
    input  logic              sel_lo_n_l,
    input  logic              sel_hi_l,
    input  logic              we_n_l,
    input  logic              oe_n_l,
    input  logic              ld_n_l,
    input  logic              inc_n_l,
    input  logic              clr_n_l,
    input  logic              lat2_l,
    input  logic              clk_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] din_r,
    output logic [DATA_W-1:0] dout_r,
    output logic              dout_en_r,
    input  logic              sel_lo_n_r,
    input  logic              sel_hi_r,
    input  logic              we_n_r,
    input  logic              oe_n_r,
    input  logic              ld_n_r,
    input  logic              inc_n_r,
    input  logic              clr_n_r,
    input  logic              lat2_r
);

    logic [ADDR_W-1:0] acc_l, acc_r, cnt_l, cnt_r;
    logic [DATA_W-1:0] rdw_l, rdw_r;
    logic              wr_l, wr_r, wr_r_kept;

    dpb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_l_i (
        .clk        (clk_l),
        .rst_n      (rst_n),
        .addr_i     (addr_l),
        .sel_lo_n_i (sel_lo_n_l),
        .sel_hi_i   (sel_hi_l),
        .we_n_i     (we_n_l),
        .oe_n_i     (oe_n_l),
        .ld_n_i     (ld_n_l),
        .inc_n_i    (inc_n_l),
        .clr_n_i    (clr_n_l),
        .lat2_i     (lat2_l),
        .rd_data_i  (rdw_l),
        .acc_addr_o (acc_l),
        .wr_o       (wr_l),
        .cnt_o      (cnt_l),
        .dout_o     (dout_l),
        .dout_en_o  (dout_en_l)
    );

    dpb_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_r_i (
        .clk        (clk_r),
        .rst_n      (rst_n),
        .addr_i     (addr_r),
        .sel_lo_n_i (sel_lo_n_r),
        .sel_hi_i   (sel_hi_r),
        .we_n_i     (we_n_r),
        .oe_n_i     (oe_n_r),
        .ld_n_i     (ld_n_r),
        .inc_n_i    (inc_n_r),
        .clr_n_i    (clr_n_r),
        .lat2_i     (lat2_r),
        .rd_data_i  (rdw_r),
        .acc_addr_o (acc_r),
        .wr_o       (wr_r),
        .cnt_o      (cnt_r),
        .dout_o     (dout_r),
        .dout_en_o  (dout_en_r)
    );

    // Left wins a same-word write: drop the right write.
    always_comb wr_r_kept = wr_r && !(wr_l && (acc_l == acc_r));

    dpb_xor_banks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk_a    (clk_l),
        .we_a_i   (wr_l),
        .addr_a_i (acc_l),
        .wd_a_i   (din_l),
        .rd_a_o   (rdw_l),
        .clk_b    (clk_r),
        .we_b_i   (wr_r_kept),
        .addr_b_i (acc_r),
        .wd_b_i   (din_r),
        .rd_b_o   (rdw_r)
    );

endmodule

// File: rtl/dpb_burst_ram_chk.sv
// Checker: counter priority, wrap, output-enable gating and deselect
// behaviour, bound to dpb_burst_ram.
module dpb_burst_ram_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              rst_n,
    input logic              clk_l,
    input logic              clk_r,
    input logic [ADDR_W-1:0] addr_l,
    input logic [ADDR_W-1:0] cnt_l,
    input logic [ADDR_W-1:0] cnt_r,
    input logic              clr_n_l,
    input logic              ld_n_l,
    input logic              inc_n_l,
    input logic              clr_n_r,
    input logic              oe_n_l,
    input logic              oe_n_r,
    input logic              dout_en_l,
    input logic              dout_en_r,
    input logic              sel_lo_n_l,
    input logic              sel_hi_l,
    input logic              lat2_l
);

    localparam logic [ADDR_W-1:0] TOP = '1;

    assert_clear_wins_R8: assert property (@(posedge clk_l) disable iff (!rst_n)
        !clr_n_l |=> cnt_l == '0);

    assert_clear_right_R8: assert property (@(posedge clk_r) disable iff (!rst_n)
        !clr_n_r |=> cnt_r == '0);

    assert_load_R6: assert property (@(posedge clk_l) disable iff (!rst_n)
        (clr_n_l && !ld_n_l) |=> cnt_l == $past(addr_l));

    assert_step_R7: assert property (@(posedge clk_l) disable iff (!rst_n)
        (clr_n_l && ld_n_l && !inc_n_l) |=> cnt_l == ADDR_W'($past(cnt_l) + 1'b1));

    assert_hold_R7: assert property (@(posedge clk_l) disable iff (!rst_n)
        (clr_n_l && ld_n_l && inc_n_l) |=> $stable(cnt_l));

    assert_wrap_R10: assert property (@(posedge clk_l) disable iff (!rst_n)
        (clr_n_l && ld_n_l && !inc_n_l && cnt_l == TOP) |=> cnt_l == '0);

    assert_oe_gate_l_R3: assert property (@(posedge clk_l) disable iff (!rst_n)
        oe_n_l |-> !dout_en_l);

    assert_oe_gate_r_R3: assert property (@(posedge clk_r) disable iff (!rst_n)
        oe_n_r |-> !dout_en_r);

    assert_deselect_R1: assert property (@(posedge clk_l) disable iff (!rst_n)
        (!(!sel_lo_n_l && sel_hi_l) && !lat2_l) |=> (lat2_l || !dout_en_l));

endmodule

bind dpb_burst_ram dpb_burst_ram_chk #(.ADDR_W(ADDR_W)) chk_i (
    .rst_n      (rst_n),
    .clk_l      (clk_l),
    .clk_r      (clk_r),
    .addr_l     (addr_l),
    .cnt_l      (cnt_l),
    .cnt_r      (cnt_r),
    .clr_n_l    (clr_n_l),
    .ld_n_l     (ld_n_l),
    .inc_n_l    (inc_n_l),
    .clr_n_r    (clr_n_r),
    .oe_n_l     (oe_n_l),
    .oe_n_r     (oe_n_r),
    .dout_en_l  (dout_en_l),
    .dout_en_r  (dout_en_r),
    .sel_lo_n_l (sel_lo_n_l),
    .sel_hi_l   (sel_hi_l),
    .lat2_l     (lat2_l)
);

// File: tb/dpb_burst_ram_tb.sv
// Directed bench: one task per scenario, both ports on one 100 MHz clock.
module dpb_burst_ram_tb_top;

    localparam int AW = 11;
    localparam int DW = 9;
    localparam logic [AW-1:0] TOPA = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] addr_l, addr_r;
    logic [DW-1:0] din_l, din_r, dout_l, dout_r;
    logic dout_en_l, dout_en_r;
    logic sel_lo_n_l, sel_hi_l, we_n_l, oe_n_l, ld_n_l, inc_n_l, clr_n_l, lat2_l;
    logic sel_lo_n_r, sel_hi_r, we_n_r, oe_n_r, ld_n_r, inc_n_r, clr_n_r, lat2_r;

    int checks = 0;
    int errors = 0;

    dpb_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .rst_n(rst_n),
        .clk_l(clk), .addr_l(addr_l), .din_l(din_l), .dout_l(dout_l),
        .dout_en_l(dout_en_l), .sel_lo_n_l(sel_lo_n_l), .sel_hi_l(sel_hi_l),
        .we_n_l(we_n_l), .oe_n_l(oe_n_l), .ld_n_l(ld_n_l), .inc_n_l(inc_n_l),
        .clr_n_l(clr_n_l), .lat2_l(lat2_l),
        .clk_r(clk), .addr_r(addr_r), .din_r(din_r), .dout_r(dout_r),
        .dout_en_r(dout_en_r), .sel_lo_n_r(sel_lo_n_r), .sel_hi_r(sel_hi_r),
        .we_n_r(we_n_r), .oe_n_r(oe_n_r), .ld_n_r(ld_n_r), .inc_n_r(inc_n_r),
        .clr_n_r(clr_n_r), .lat2_r(lat2_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // side 0 = left, 1 = right; sel=1 drives both selects active.
    task automatic drive(input bit side, input bit sel, input bit we_n, input bit ld_n,
                         input bit inc_n, input bit clr_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (!side) begin
            sel_lo_n_l = !sel; sel_hi_l = sel; we_n_l = we_n; ld_n_l = ld_n;
            inc_n_l = inc_n; clr_n_l = clr_n; addr_l = a; din_l = d;
        end else begin
            sel_lo_n_r = !sel; sel_hi_r = sel; we_n_r = we_n; ld_n_r = ld_n;
            inc_n_r = inc_n; clr_n_r = clr_n; addr_r = a; din_r = d;
        end
    endtask

    task automatic idle(input bit side);
        drive(side, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic wr1(input bit side, input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(side, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, a, d);
        tick();
        idle(side);
    endtask

    // Flow-through read with explicit address; checks data and enable.
    task automatic rd_flow(input bit side, input logic [AW-1:0] a,
                           input logic [DW-1:0] exp, input string tag);
        drive(side, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, a, '0);
        tick();
        chk({tag, " data"}, side ? dout_r : dout_l, exp);
        chk({tag, " enable"}, side ? dout_en_r : dout_en_l, 1);
        idle(side);
    endtask

    task automatic t_reset;
        idle(0); idle(1);
        oe_n_l = 0; oe_n_r = 0; lat2_l = 0; lat2_r = 0;
        rst_n = 0;
        repeat (3) tick();
        chk("R13 left enable in reset", dout_en_l, 0);
        chk("R13 right enable in reset", dout_en_r, 0);
        rst_n = 1;
        // Counter is 0 after reset: counter-addressed write lands at word 0.
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h155, 9'h1A5);
        tick();
        idle(0);
        rd_flow(1, 11'h000, 9'h1A5, "R13/R9 counter zero after reset");
    endtask

    task automatic t_basic;
        wr1(0, 11'h010, 9'h0AB);
        rd_flow(1, 11'h010, 9'h0AB, "R11/R4 right reads left write");
        wr1(1, 11'h011, 9'h1C3);
        rd_flow(0, 11'h011, 9'h1C3, "R2/R11 left reads right write");
        rd_flow(0, 11'h010, 9'h0AB, "R4 left flow read");
    endtask

    task automatic t_pipe;
        lat2_r = 1;
        tick();
        drive(1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 11'h010, '0);
        tick();
        chk("R5 no data after first edge", dout_en_r, 0);
        idle(1);
        tick();
        chk("R5 pipelined data", dout_r, 9'h0AB);
        chk("R5 pipelined enable", dout_en_r, 1);
        lat2_r = 0;
        tick();
    endtask

    task automatic t_oe;
        oe_n_l = 1;
        drive(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 11'h011, '0);
        tick();
        chk("R3 enable low while oe high", dout_en_l, 0);
        oe_n_l = 0;
        #1;
        chk("R3 enable follows oe", dout_en_l, 1);
        chk("R3 data present", dout_l, 9'h1C3);
        idle(0);
        tick();
    endtask

    task automatic t_deselect;
        // Only one select active: no write, no read.
        sel_lo_n_l = 0; sel_hi_l = 0; we_n_l = 0; ld_n_l = 0;
        addr_l = 11'h010; din_l = 9'h155;
        tick();
        sel_lo_n_l = 1; sel_hi_l = 1; we_n_l = 1;
        tick();
        chk("R1 half-selected read no enable", dout_en_l, 0);
        idle(0);
        rd_flow(1, 11'h010, 9'h0AB, "R1 half-selected write ignored");
    endtask

    task automatic t_burst;
        drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 11'h020, 9'h101); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 9'h102); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 9'h103); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 9'h104); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 9'h105); tick();
        idle(0);
        rd_flow(1, 11'h020, 9'h102, "R6/R7 load then step ignored during load");
        rd_flow(1, 11'h021, 9'h103, "R7/R9 stepped access");
        rd_flow(1, 11'h022, 9'h105, "R7 hold when no step");
    endtask

    task automatic t_clear;
        drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'h030, 9'h0F0); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 9'h0F1); tick();
        idle(0);
        rd_flow(1, 11'h030, 9'h0F0, "R9 load cycle uses pins");
        rd_flow(1, 11'h000, 9'h0F1, "R8 clear beats load");
        drive(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 11'h050, '0); tick();
        drive(0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h000, '0); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 9'h0F2); tick();
        idle(0);
        rd_flow(1, 11'h000, 9'h0F2, "R8 clear beats step");
    endtask

    task automatic t_wrap;
        drive(0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, TOPA, 9'h111); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 9'h112); tick();
        drive(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 9'h113); tick();
        idle(0);
        rd_flow(1, TOPA, 9'h112, "R10 top word");
        rd_flow(1, 11'h000, 9'h113, "R10 wrap to zero");
    endtask

    task automatic t_collide;
        drive(0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h040, 9'h0AA);
        drive(1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h040, 9'h155);
        tick();
        drive(0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h041, 9'h011);
        drive(1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 11'h042, 9'h022);
        tick();
        idle(0); idle(1);
        rd_flow(1, 11'h040, 9'h0AA, "R12 left wins same word");
        rd_flow(0, 11'h041, 9'h011, "R11 left word of dual write");
        rd_flow(0, 11'h042, 9'h022, "R11 right word of dual write");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pipe();
        t_oe();
        t_deselect();
        t_burst();
        t_clear();
        t_wrap();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog all requirements: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule